// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the ready stage of an out-of-order core and its execution units. Ready instructions arrive one per cycle. Each carries an operation class, a sequence number and a thread ID, and it waits in a small ready set that belongs to its class. Each cycle the block ranks the classes that hold work by the sequence number of their oldest live entry, oldest first. It walks that ranking and sends up to `ISSUE_W` instructions to execution. A lower sequence number means an older instruction.

During the walk, a squashed head is thrown away without using an issue slot. A class whose execution unit is still occupied is passed over, and its stall counter goes up. A class that needs no unit issues at once. A pipelined unit can accept work again on the next cycle. A non-pipelined unit stays reserved for its issue interval. Grants are registered and carry the class, the sequence number and the result latency. A squash input marks the entries of one thread that are younger than a boundary, so the walk drops them.

Top module: `age_issue_select`

## Requirements
- R1: After a synchronous active-low reset, no grant is valid and every per-class stall counter reads zero.
- R2: Within one class, the entry with the lowest sequence number is always issued first. This holds even when an older entry arrives after younger ones of the same class.
- R3: The grants of one cycle are packed from slot 0 upward, in ascending sequence-number order across classes. When two class heads carry equal sequence numbers, the lower class index goes first.
- R4: At most `ISSUE_W` grants are made per cycle, and each class issues at most once per cycle. Ready work beyond that waits for later cycles.
- R5: While `ex_ready` is low, the block makes no grant, drops no squashed entry and leaves the stall counters unchanged.
- R6: A pulse on `kill_valid` marks as squashed every held entry of thread `kill_tid` whose sequence number is above `kill_seq`. When a squashed entry reaches the head of its class during the walk, it is removed without a grant and without using a slot.
- R7: When a live head's class unit is occupied, that class is skipped for the cycle and its stall counter (field `busy_cnt[c*BUSY_W +: BUSY_W]`) increases by one. The walk then goes on to younger classes, and the counter never decreases.
- R8: A class whose `NEEDS_UNIT` bit is clear (class 0 by default) issues without reserving a unit.
- R9: A unit with an issue interval of 1 (classes 1 and 3 by default) can be used again on the next cycle. A unit with an interval of L greater than 1 (class 2, L=4) that is taken at cycle t is free again at cycle t+L.
- R10: An entry written at clock edge k can be granted at edge k+1 at the earliest. Slot s reports `grant_class[s*CLS_W +: CLS_W]`, `grant_seq[s*SEQ_W +: SEQ_W]` and `grant_lat[s*4 +: 4]`, and its latency equals the class's `OP_LAT` field (1, 3, 4 and 1 for classes 0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Write one ready instruction this cycle |
| enq_class | input | CLS_W | Operation class of the written instruction |
| enq_seq | input | SEQ_W | Sequence number (lower is older) |
| enq_tid | input | TID_W | Thread ID |
| kill_valid | input | 1 | Squash request |
| kill_tid | input | TID_W | Thread being squashed |
| kill_seq | input | SEQ_W | Entries strictly younger than this are squashed |
| ex_ready | input | 1 | Execution stage can accept issued work |
| grant_valid | output | ISSUE_W | Per-slot grant valid |
| grant_class | output | ISSUE_W*CLS_W | Per-slot class |
| grant_seq | output | ISSUE_W*SEQ_W | Per-slot sequence number |
| grant_lat | output | ISSUE_W*4 | Per-slot result latency |
| busy_cnt | output | NUM_CLASS*BUSY_W | Per-class saturating stall counters |

## Verification
The checks assume certain things about the inputs. A class never receives more entries than `DEPTH` while it still holds work. Sequence numbers do not wrap within a run. Every `ISSUE_LAT` field is at least 1. The stimulus respects these limits: no scenario keeps more than four entries in one class, all sequence numbers stay well below 256, and the bench drains the block and idles long enough for every unit to come free before the next scenario starts. Squash requests are sent on a cycle with no write and with `ex_ready` low, so the marking is settled before any walk sees it.

// File: rtl/isel_pkg.sv
// Shared constants and types for the issue selector.
// Assumes latency fields are 4 bits wide throughout the block.
package isel_pkg;
    localparam int LAT_W = 4;

    // What the walk did with one class in the current cycle.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_DROP  = 2'd1,
        ACT_ISSUE = 2'd2,
        ACT_BUSY  = 2'd3
    } walk_act_e;
endpackage

// File: rtl/isel_ready_q.sv
// Ready set of one operation class. Presents the entry with the lowest
// sequence number as head. Assumes the caller never writes to a full set
// and that sequence numbers do not wrap while entries are held.
module isel_ready_q #(
    parameter int DEPTH = 4,
    parameter int SEQ_W = 8,
    parameter int TID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic [TID_W-1:0] push_tid,
    input  logic             pop,
    input  logic             kill_en,
    input  logic [TID_W-1:0] kill_tid,
    input  logic [SEQ_W-1:0] kill_seq,
    output logic             head_valid,
    output logic [SEQ_W-1:0] head_seq,
    output logic             head_dead
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]            vld;
    logic [DEPTH-1:0]            dead;
    logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
    logic [DEPTH-1:0][TID_W-1:0] tid_q;
    logic [IDX_W-1:0]            head_idx;
    logic [IDX_W-1:0]            free_idx;
    logic                        free_found;

    // Locate the oldest held entry.
    always_comb begin
        head_idx   = '0;
        head_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && (!head_valid || seq_q[i] < seq_q[head_idx])) begin
                head_idx   = IDX_W'(i);
                head_valid = 1'b1;
            end
        end
    end

    // Locate the lowest-index empty slot.
    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld[i] && !free_found) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
    end

    assign head_seq  = seq_q[head_idx];
    assign head_dead = dead[head_idx];

    // Mark squashed entries, retire the head, store a new entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= '0;
            dead  <= '0;
            seq_q <= '0;
            tid_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (kill_en && vld[i] && tid_q[i] == kill_tid && seq_q[i] > kill_seq)
                    dead[i] <= 1'b1;
            end
            if (pop)
                vld[head_idx] <= 1'b0;
            if (push && free_found) begin
                vld[free_idx]   <= 1'b1;
                seq_q[free_idx] <= push_seq;
                tid_q[free_idx] <= push_tid;
                dead[free_idx]  <= kill_en && push_tid == kill_tid && push_seq > kill_seq;
            end
        end
    end
endmodule

// File: rtl/isel_unit_timer.sv
// Occupancy of one execution unit. A take reserves the unit for HOLD
// cycles, counting the take cycle. HOLD of 1 models a pipelined unit.
// Assumes HOLD >= 1 and HOLD < 2**CNT_W.
module isel_unit_timer #(
    parameter int HOLD  = 1,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic free
);
    logic [CNT_W-1:0] cnt;

    assign free = (cnt == '0);

    // Load the reservation on a take, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (take)
            cnt <= CNT_W'(HOLD - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/isel_walk.sv
// Ranks non-empty classes by head age and walks them, oldest first.
// Per class it decides to drop, issue or report a busy unit, and it packs
// issued classes into grant slots. Equal heads rank the lower class first.
// Purely combinational. Each class is visited at most once per cycle.
module isel_walk
    import isel_pkg::*;
#(
    parameter int NUM_CLASS = 4,
    parameter int SEQ_W     = 8,
    parameter int ISSUE_W   = 2,
    parameter int CLS_W     = 2
) (
    input  logic [NUM_CLASS-1:0]            head_valid,
    input  logic [NUM_CLASS-1:0][SEQ_W-1:0] head_seq,
    input  logic [NUM_CLASS-1:0]            head_dead,
    input  logic [NUM_CLASS-1:0]            unit_free,
    input  logic [NUM_CLASS-1:0]            needs_unit,
    input  logic                            ex_ready,
    output walk_act_e                       act [NUM_CLASS],
    output logic [ISSUE_W-1:0]              slot_v,
    output logic [ISSUE_W-1:0][CLS_W-1:0]   slot_cls
);
    logic [NUM_CLASS-1:0][CLS_W-1:0] rank;
    logic [NUM_CLASS-1:0][CLS_W-1:0] order;
    logic [NUM_CLASS-1:0]            order_v;

    // Rank of each class = number of non-empty classes with an older head.
    always_comb begin
        for (int c = 0; c < NUM_CLASS; c++) begin
            rank[c] = '0;
            for (int d = 0; d < NUM_CLASS; d++) begin
                if (d != c && head_valid[d] &&
                    (head_seq[d] < head_seq[c] || (head_seq[d] == head_seq[c] && d < c)))
                    rank[c] = rank[c] + 1'b1;
            end
        end
    end

    // Invert the ranking into an age-ordered class list.
    always_comb begin
        for (int p = 0; p < NUM_CLASS; p++) begin
            order_v[p] = 1'b0;
            order[p]   = '0;
            for (int c = 0; c < NUM_CLASS; c++) begin
                if (head_valid[c] && rank[c] == CLS_W'(p)) begin
                    order_v[p] = 1'b1;
                    order[p]   = CLS_W'(c);
                end
            end
        end
    end

    // Walk the list while slots remain and execution accepts work.
    always_comb begin
        int used;
        used     = 0;
        slot_v   = '0;
        slot_cls = '0;
        for (int c = 0; c < NUM_CLASS; c++)
            act[c] = ACT_NONE;
        for (int p = 0; p < NUM_CLASS; p++) begin
            if (order_v[p] && ex_ready && used < ISSUE_W) begin
                if (head_dead[order[p]]) begin
                    act[order[p]] = ACT_DROP;
                end else if (!needs_unit[order[p]] || unit_free[order[p]]) begin
                    act[order[p]]  = ACT_ISSUE;
                    slot_v[used]   = 1'b1;
                    slot_cls[used] = order[p];
                    used           = used + 1;
                end else begin
                    act[order[p]] = ACT_BUSY;
                end
            end
        end
    end
endmodule

// File: rtl/age_issue_select.sv
// Top of the oldest-first issue selector. Holds one ready set and, where
// needed, one unit timer per class. Registers up to ISSUE_W grants per
// cycle and keeps saturating per-class stall counters.
// Assumes the producer never overfills a class and sequence numbers do not
// wrap. Latency parameters pack 4-bit fields, class 0 in the low bits.
module age_issue_select
    import isel_pkg::*;
#(
    parameter int NUM_CLASS = 4,
    parameter int DEPTH     = 4,
    parameter int SEQ_W     = 8,
    parameter int TID_W     = 1,
    parameter int ISSUE_W   = 2,
    parameter int BUSY_W    = 8,
    parameter logic [NUM_CLASS-1:0]       NEEDS_UNIT = 4'b1110,
    parameter logic [NUM_CLASS*LAT_W-1:0] OP_LAT     = {4'd1, 4'd4, 4'd3, 4'd1},
    parameter logic [NUM_CLASS*LAT_W-1:0] ISSUE_LAT  = {4'd1, 4'd4, 4'd1, 4'd1},
    localparam int CLS_W = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq_valid,
    input  logic [CLS_W-1:0]              enq_class,
    input  logic [SEQ_W-1:0]              enq_seq,
    input  logic [TID_W-1:0]              enq_tid,
    input  logic                          kill_valid,
    input  logic [TID_W-1:0]              kill_tid,
    input  logic [SEQ_W-1:0]              kill_seq,
    input  logic                          ex_ready,
    output logic [ISSUE_W-1:0]            grant_valid,
    output logic [ISSUE_W*CLS_W-1:0]      grant_class,
    output logic [ISSUE_W*SEQ_W-1:0]      grant_seq,
    output logic [ISSUE_W*LAT_W-1:0]      grant_lat,
    output logic [NUM_CLASS*BUSY_W-1:0]   busy_cnt
);
    logic [NUM_CLASS-1:0]            head_valid;
    logic [NUM_CLASS-1:0][SEQ_W-1:0] head_seq;
    logic [NUM_CLASS-1:0]            head_dead;
    logic [NUM_CLASS-1:0]            unit_free;
    walk_act_e                       act [NUM_CLASS];
    logic [ISSUE_W-1:0]              slot_v;
    logic [ISSUE_W-1:0][CLS_W-1:0]   slot_cls;

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        isel_ready_q #(
            .DEPTH (DEPTH),
            .SEQ_W (SEQ_W),
            .TID_W (TID_W)
        ) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (enq_valid && enq_class == CLS_W'(c)),
            .push_seq   (enq_seq),
            .push_tid   (enq_tid),
            .pop        (act[c] == ACT_ISSUE || act[c] == ACT_DROP),
            .kill_en    (kill_valid),
            .kill_tid   (kill_tid),
            .kill_seq   (kill_seq),
            .head_valid (head_valid[c]),
            .head_seq   (head_seq[c]),
            .head_dead  (head_dead[c])
        );

        if (NEEDS_UNIT[c]) begin : g_unit
            isel_unit_timer #(
                .HOLD  (int'(ISSUE_LAT[c*LAT_W +: LAT_W])),
                .CNT_W (LAT_W)
            ) u_t (
                .clk   (clk),
                .rst_n (rst_n),
                .take  (act[c] == ACT_ISSUE),
                .free  (unit_free[c])
            );
        end else begin : g_nounit
            assign unit_free[c] = 1'b1;
        end
    end

    isel_walk #(
        .NUM_CLASS (NUM_CLASS),
        .SEQ_W     (SEQ_W),
        .ISSUE_W   (ISSUE_W),
        .CLS_W     (CLS_W)
    ) u_walk (
        .head_valid (head_valid),
        .head_seq   (head_seq),
        .head_dead  (head_dead),
        .unit_free  (unit_free),
        .needs_unit (NEEDS_UNIT),
        .ex_ready   (ex_ready),
        .act        (act),
        .slot_v     (slot_v),
        .slot_cls   (slot_cls)
    );

    // Register the packed grant slots with their sequence number and latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= '0;
            grant_class <= '0;
            grant_seq   <= '0;
            grant_lat   <= '0;
        end else begin
            for (int s = 0; s < ISSUE_W; s++) begin
                grant_valid[s]                  <= slot_v[s];
                grant_class[s*CLS_W +: CLS_W]   <= slot_cls[s];
                grant_seq[s*SEQ_W +: SEQ_W]     <= head_seq[slot_cls[s]];
                grant_lat[s*LAT_W +: LAT_W]     <= OP_LAT[int'(slot_cls[s])*LAT_W +: LAT_W];
            end
        end
    end

    // Count walks that found the class unit occupied; saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else begin
            for (int c = 0; c < NUM_CLASS; c++) begin
                if (act[c] == ACT_BUSY && busy_cnt[c*BUSY_W +: BUSY_W] != {BUSY_W{1'b1}})
                    busy_cnt[c*BUSY_W +: BUSY_W] <= busy_cnt[c*BUSY_W +: BUSY_W] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/age_issue_select_chk.sv
// Temporal checks on the issue selector's ports, bound to its top.
// Assumes inputs keep to the limits stated for the block.
module age_issue_select_chk
    import isel_pkg::*;
#(
    parameter int NUM_CLASS = 4,
    parameter int SEQ_W     = 8,
    parameter int ISSUE_W   = 2,
    parameter int BUSY_W    = 8,
    parameter int CLS_W     = 2,
    parameter logic [NUM_CLASS*LAT_W-1:0] ISSUE_LAT = '0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ex_ready,
    input logic [ISSUE_W-1:0]          grant_valid,
    input logic [ISSUE_W*CLS_W-1:0]    grant_class,
    input logic [ISSUE_W*SEQ_W-1:0]    grant_seq,
    input logic [NUM_CLASS*BUSY_W-1:0] busy_cnt
);
    logic [NUM_CLASS-1:0][ISSUE_W-1:0] hit;
    logic [NUM_CLASS-1:0]              class_hit;

    // Which slots granted each class this cycle.
    always_comb begin
        for (int c = 0; c < NUM_CLASS; c++) begin
            for (int s = 0; s < ISSUE_W; s++)
                hit[c][s] = grant_valid[s] && grant_class[s*CLS_W +: CLS_W] == CLS_W'(c);
            class_hit[c] = |hit[c];
        end
    end

    for (genvar s = 1; s < ISSUE_W; s++) begin : g_slot
        AST_SLOT_AGE: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid[s] |-> grant_valid[s-1] &&
            grant_seq[(s-1)*SEQ_W +: SEQ_W] <= grant_seq[s*SEQ_W +: SEQ_W]); // R3
    end

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ex_ready) |-> grant_valid == '0); // R5

    AST_STALL_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ex_ready) |-> busy_cnt == $past(busy_cnt)); // R5

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        AST_CLASS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit[c]) <= 1); // R4

        AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            busy_cnt[c*BUSY_W +: BUSY_W] != $past(busy_cnt[c*BUSY_W +: BUSY_W]) |-> !class_hit[c]); // R7

        AST_BUSY_MONO: assert property (@(posedge clk) disable iff (!rst_n)
            busy_cnt[c*BUSY_W +: BUSY_W] >= $past(busy_cnt[c*BUSY_W +: BUSY_W])); // R7

        if (ISSUE_LAT[c*LAT_W +: LAT_W] > 1) begin : g_np
            AST_NONPIPE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                class_hit[c] |=> !class_hit[c]); // R9
        end
    end
endmodule

bind age_issue_select age_issue_select_chk #(
    .NUM_CLASS (NUM_CLASS),
    .SEQ_W     (SEQ_W),
    .ISSUE_W   (ISSUE_W),
    .BUSY_W    (BUSY_W),
    .CLS_W     (CLS_W),
    .ISSUE_LAT (ISSUE_LAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_ready    (ex_ready),
    .grant_valid (grant_valid),
    .grant_class (grant_class),
    .grant_seq   (grant_seq),
    .busy_cnt    (busy_cnt)
);

// File: tb/sim_age_issue_select.sv
`timescale 1ns/1ps
// Directed scenarios plus a sweep over every ordered class pair, on the
// default configuration (4 classes, issue width 2).
module sim_age_issue_select;
    localparam int CW = 2;
    localparam int SW = 8;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enq_valid;
    logic [CW-1:0] enq_class;
    logic [SW-1:0] enq_seq;
    logic          enq_tid;
    logic          kill_valid;
    logic          kill_tid;
    logic [SW-1:0] kill_seq;
    logic          ex_ready;
    logic [1:0]    grant_valid;
    logic [2*CW-1:0] grant_class;
    logic [2*SW-1:0] grant_seq;
    logic [7:0]    grant_lat;
    logic [4*BW-1:0] busy_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    age_issue_select u0 (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_class(enq_class),
        .enq_seq(enq_seq), .enq_tid(enq_tid), .kill_valid(kill_valid),
        .kill_tid(kill_tid), .kill_seq(kill_seq), .ex_ready(ex_ready),
        .grant_valid(grant_valid), .grant_class(grant_class), .grant_seq(grant_seq),
        .grant_lat(grant_lat), .busy_cnt(busy_cnt)
    );

    always #10 clk = ~clk;

    function automatic int exp_lat(input int c);
        case (c)
            0: return 1;
            1: return 3;
            2: return 4;
            default: return 1;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enq(input int c, input int s, input int t);
        enq_valid = 1'b1;
        enq_class = CW'(c);
        enq_seq   = SW'(s);
        enq_tid   = t[0];
        step();
        enq_valid = 1'b0;
    endtask

    task automatic chk_slot(input int s, input bit v, input int c, input int sq, input string req);
        bit ok;
        int gc, gs, gl;
        gc = int'(grant_class[s*CW +: CW]);
        gs = int'(grant_seq[s*SW +: SW]);
        gl = int'(grant_lat[s*4 +: 4]);
        n_chk++;
        if (v) ok = grant_valid[s] && gc == c && gs == sq && gl == exp_lat(c);
        else   ok = !grant_valid[s];
        if (!ok) begin
            n_fail++;
            $display("FAIL %s slot%0d: got v=%0b cls=%0d seq=%0d lat=%0d, expected v=%0b cls=%0d seq=%0d lat=%0d",
                     req, s, grant_valid[s], gc, gs, gl, v, c, sq, exp_lat(c));
        end
    endtask

    task automatic chk_val(input string req, input int got, input int want);
        n_chk++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: got %0d, expected %0d", req, got, want);
        end
    endtask

    function automatic int busy_of(input int c);
        return int'(busy_cnt[c*BW +: BW]);
    endfunction

    task automatic idle(input int n);
        ex_ready = 1'b0;
        repeat (n) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: got still running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int b2;
        rst_n = 1'b0; enq_valid = 1'b0; enq_class = '0; enq_seq = '0; enq_tid = 1'b0;
        kill_valid = 1'b0; kill_tid = 1'b0; kill_seq = '0; ex_ready = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk_slot(0, 0, 0, 0, "R1");
        chk_slot(1, 0, 0, 0, "R1");
        for (int c = 0; c < 4; c++) chk_val("R1 busy", busy_of(c), 0);

        // R2/R5: older entry overtakes its class head; nothing moves while held
        enq(1, 30, 0); enq(3, 20, 0); enq(1, 10, 0);
        step(); step();
        chk_slot(0, 0, 0, 0, "R5 hold");
        for (int c = 0; c < 4; c++) chk_val("R5 busy", busy_of(c), 0);
        ex_ready = 1'b1;
        step();
        chk_slot(0, 1, 1, 10, "R2");
        chk_slot(1, 1, 3, 20, "R3");
        step();
        chk_slot(0, 1, 1, 30, "R2");
        chk_slot(1, 0, 0, 0, "R2");
        idle(2);

        // R4/R8: width limit, unit-free class 0
        enq(0, 5, 0); enq(1, 6, 0); enq(3, 7, 0);
        ex_ready = 1'b1;
        step();
        chk_slot(0, 1, 0, 5, "R8");
        chk_slot(1, 1, 1, 6, "R4");
        step();
        chk_slot(0, 1, 3, 7, "R4");
        chk_slot(1, 0, 0, 0, "R4");
        idle(2);

        // R3: equal heads, lower class first
        enq(3, 70, 0); enq(0, 70, 0);
        ex_ready = 1'b1;
        step();
        chk_slot(0, 1, 0, 70, "R3 tie");
        chk_slot(1, 1, 3, 70, "R3 tie");
        idle(2);

        // R6: squash thread 1 above 39
        enq(0, 40, 1); enq(0, 41, 0); enq(3, 42, 1);
        kill_valid = 1'b1; kill_tid = 1'b1; kill_seq = 8'd39;
        step();
        kill_valid = 1'b0;
        ex_ready = 1'b1;
        step();
        chk_slot(0, 0, 0, 0, "R6 drop");
        step();
        chk_slot(0, 1, 0, 41, "R6");
        chk_slot(1, 0, 0, 0, "R6");
        step();
        chk_slot(0, 0, 0, 0, "R6 empty");
        idle(2);

        // R7/R9: non-pipelined class 2 busy for 3 cycles, class 3 proceeds
        b2 = busy_of(2);
        enq(2, 50, 0); enq(2, 51, 0); enq(3, 52, 0); enq(3, 53, 0);
        ex_ready = 1'b1;
        step();
        chk_slot(0, 1, 2, 50, "R9");
        chk_slot(1, 1, 3, 52, "R3");
        step();
        chk_slot(0, 1, 3, 53, "R7 walk on");
        chk_slot(1, 0, 0, 0, "R7");
        step();
        chk_slot(0, 0, 0, 0, "R9 held");
        step();
        chk_slot(0, 0, 0, 0, "R9 held");
        step();
        chk_slot(0, 1, 2, 51, "R9 release");
        chk_val("R7 busy count", busy_of(2) - b2, 3);
        idle(5);

        // R9: pipelined class 1 back to back
        enq(1, 60, 0); enq(1, 61, 0);
        ex_ready = 1'b1;
        step();
        chk_slot(0, 1, 1, 60, "R9 pipe");
        step();
        chk_slot(0, 1, 1, 61, "R9 pipe");
        chk_val("R9 no busy", busy_of(1), 0);
        idle(2);

        // R10: earliest grant is one edge after the write
        ex_ready = 1'b1;
        enq(0, 90, 0);
        chk_slot(0, 0, 0, 0, "R10 early");
        step();
        chk_slot(0, 1, 0, 90, "R10");
        idle(2);

        // R3/R10: sweep ordered class pairs in both age orders
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int o = 0; o < 2; o++) begin
                    int sa, sb;
                    if (a == b) continue;
                    sa = (o == 0) ? 10 : 30;
                    sb = (o == 0) ? 30 : 10;
                    enq(a, sa, 0); enq(b, sb, 0);
                    ex_ready = 1'b1;
                    step();
                    if (sa < sb) begin
                        chk_slot(0, 1, a, sa, "R3 sweep");
                        chk_slot(1, 1, b, sb, "R10 sweep");
                    end else begin
                        chk_slot(0, 1, b, sb, "R3 sweep");
                        chk_slot(1, 1, a, sa, "R10 sweep");
                    end
                    idle(5);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule